// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a video raster, clocked by the pixel clock. Software describes each axis with four numbers: the total period, the blanking length, the distance from the sync leading edge to the end of the period, and the sync width. This replaces the usual front-porch and back-porch description. Each line and each frame begins with its active region. Separate control bits choose the active level of each sync output and turn on interlaced operation.

Configuration arrives through a byte-wide write port. Sixteen-bit horizontal quantities and the vertical total are split into low and high bytes. The other vertical quantities are one byte each. Writes land in a shadow bank, and the running timing takes the whole bank at the frame boundary. In interlaced mode, consecutive fields alternate. On the second field the vertical sync edges move by half a line.

Top module: `hv_raster_gen`

## Requirements
- R1: After a synchronous active-low reset, hsync_o, vsync_o, de_o and field_o are 0. The control byte then reads enable 0, both polarity bits 1 and interlace 0, and every timing field is 0.
- R2: Write address map. 0 is the control byte: bit0 enable, bit1 hsync polarity, bit2 vsync polarity, bit3 interlace. 1/2 are horizontal total low/high. 3/4 are horizontal blank low/high. 5/6 are horizontal delay low/high. 7/8 are horizontal sync width low/high. 9/10 are vertical total low/high. 11 is vertical blank, 12 is vertical delay and 13 is vertical sync width, one byte each.
- R3: While the generator is enabled, a write changes the running timing only at the next frame boundary, meaning the clock edge that ends the last pixel of the last line. A write issued on that same edge waits for the following boundary. While disabled, the shadow bank is taken on every clock.
- R4: Pixel count h runs from 0 to htotal-1 and line count v runs from 0 to vtotal-1. de_o is 1 exactly when h < htotal-hblank and v < vtotal-vblank. Outputs lag the counters by one clock.
- R5: hsync is active for h in [htotal-hdelay, htotal-hdelay+hwidth).
- R6: On a progressive frame or the first field, vsync is active for whole lines v in [vtotal-vdelay, vtotal-vdelay+vwidth).
- R7: A polarity bit of 1 drives the sync active-high. A bit of 0 drives it active-low, and the inactive level is the inverse.
- R8: With interlace set, field_o toggles at each frame boundary. When field_o is 1, vsync starts at pixel htotal/2 of line vtotal-vdelay and ends at pixel htotal/2 of the line vwidth lines later. A width of 0 gives no sync. With interlace clear, field_o is 0.
- R9: While disabled, both counters sit at 0, de_o is 0 and both syncs are at their inactive level.
- R10: Writes to addresses 14 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | 5 | Byte write address |
| cfg_wdata | input | 8 | Byte write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| field_o | output | 1 | Current field in interlaced mode |

## Verification
A register write and the frame-boundary takeover of the shadow bank can land on the same clock edge. The bench provokes this by holding idle until its own model is at the last pixel of the last line, then issuing the write on exactly that edge. It judges the result by confirming that the new value does not show in sync or data-enable placement until one frame later. Writes in the middle of a frame, writes while disabled and random configurations are checked every cycle against the same model.

// File: rtl/hv_timing_pkg.sv
// Shared widths, register addresses and the timing configuration record.
package hv_timing_pkg;
    parameter int HW  = 16;   // horizontal field width
    parameter int VW  = 16;   // vertical total width
    parameter int VSW = 8;    // short vertical field width
    parameter int AW  = 5;    // write address width
    parameter int DW  = 8;    // write data width

    localparam logic [AW-1:0] A_CTRL   = 5'd0;
    localparam logic [AW-1:0] A_HTOT_L = 5'd1;
    localparam logic [AW-1:0] A_HTOT_H = 5'd2;
    localparam logic [AW-1:0] A_HBLK_L = 5'd3;
    localparam logic [AW-1:0] A_HBLK_H = 5'd4;
    localparam logic [AW-1:0] A_HDLY_L = 5'd5;
    localparam logic [AW-1:0] A_HDLY_H = 5'd6;
    localparam logic [AW-1:0] A_HWID_L = 5'd7;
    localparam logic [AW-1:0] A_HWID_H = 5'd8;
    localparam logic [AW-1:0] A_VTOT_L = 5'd9;
    localparam logic [AW-1:0] A_VTOT_H = 5'd10;
    localparam logic [AW-1:0] A_VBLK   = 5'd11;
    localparam logic [AW-1:0] A_VDLY   = 5'd12;
    localparam logic [AW-1:0] A_VWID   = 5'd13;

    typedef struct packed {
        logic           en;
        logic           hpol;
        logic           vpol;
        logic           ilace;
        logic [HW-1:0]  htot;
        logic [HW-1:0]  hblk;
        logic [HW-1:0]  hdly;
        logic [HW-1:0]  hwid;
        logic [VW-1:0]  vtot;
        logic [VSW-1:0] vblk;
        logic [VSW-1:0] vdly;
        logic [VSW-1:0] vwid;
    } tcfg_t;
endpackage

// File: rtl/hv_cfg_bank.sv
// Shadow and running configuration banks.
// Byte writes land in the shadow bank; the running bank copies the whole
// shadow when load is high. Assumes HW and VW exceed DW.
module hv_cfg_bank
    import hv_timing_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    output tcfg_t         act,
    output logic          nxt_ilace
);
    tcfg_t sh;

    // Shadow bank: decode one byte write per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            sh.hpol <= 1'b1;
            sh.vpol <= 1'b1;
        end else if (we) begin
            case (addr)
                A_CTRL:   {sh.ilace, sh.vpol, sh.hpol, sh.en} <= wdata[3:0];
                A_HTOT_L: sh.htot[DW-1:0]  <= wdata;
                A_HTOT_H: sh.htot[HW-1:DW] <= wdata[HW-DW-1:0];
                A_HBLK_L: sh.hblk[DW-1:0]  <= wdata;
                A_HBLK_H: sh.hblk[HW-1:DW] <= wdata[HW-DW-1:0];
                A_HDLY_L: sh.hdly[DW-1:0]  <= wdata;
                A_HDLY_H: sh.hdly[HW-1:DW] <= wdata[HW-DW-1:0];
                A_HWID_L: sh.hwid[DW-1:0]  <= wdata;
                A_HWID_H: sh.hwid[HW-1:DW] <= wdata[HW-DW-1:0];
                A_VTOT_L: sh.vtot[DW-1:0]  <= wdata;
                A_VTOT_H: sh.vtot[VW-1:DW] <= wdata[VW-DW-1:0];
                A_VBLK:   sh.vblk <= wdata[VSW-1:0];
                A_VDLY:   sh.vdly <= wdata[VSW-1:0];
                A_VWID:   sh.vwid <= wdata[VSW-1:0];
                default:  ;
            endcase
        end
    end

    // Running bank: take the shadow at a frame boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= '0;
            act.hpol <= 1'b1;
            act.vpol <= 1'b1;
        end else if (load) begin
            act <= sh;
        end
    end

    assign nxt_ilace = sh.ilace;

    // R3: running configuration moves only on a load
    p_act_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act));
endmodule

// File: rtl/hv_scan_count.sv
// Pixel and line counters with field tracking.
// Counters start at 0 on every load; load is raised when disabled or on the
// last pixel of the last line. Assumes htot >= 1 and vtot >= 1 when enabled.
module hv_scan_count
    import hv_timing_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] htot,
    input  logic [VW-1:0] vtot,
    input  logic          nxt_ilace,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          field,
    output logic          load
);
    logic last_h, last_v;

    // End-of-line and end-of-frame detection.
    always_comb begin
        last_h = (hcnt == htot - {{(HW-1){1'b0}}, 1'b1});
        last_v = (vcnt == vtot - {{(VW-1){1'b0}}, 1'b1});
        load   = !en || (last_h && last_v);
    end

    // Advance the raster position and flip the field at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt  <= '0;
            vcnt  <= '0;
            field <= 1'b0;
        end else if (load) begin
            hcnt  <= '0;
            vcnt  <= '0;
            field <= (en && nxt_ilace) ? ~field : 1'b0;
        end else if (last_h) begin
            hcnt <= '0;
            vcnt <= vcnt + {{(VW-1){1'b0}}, 1'b1};
        end else begin
            hcnt <= hcnt + {{(HW-1){1'b0}}, 1'b1};
        end
    end

    // R4: pixel counter stays inside the line
    p_hcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && htot != '0) |-> (hcnt < htot));
    // R8: field holds between boundaries
    p_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(field));
    // R9: idle generator parks both counters at zero
    p_idle_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (hcnt == '0 && vcnt == '0));
endmodule

// File: rtl/hv_sync_decode.sv
// Compares the raster position with the running configuration and registers
// hsync, vsync (polarity applied), data enable and field. Assumes
// hdly <= htot and vdly <= vtot while enabled.
module hv_sync_decode
    import hv_timing_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  tcfg_t         act,
    input  logic [HW-1:0] hcnt,
    input  logic [VW-1:0] vcnt,
    input  logic          field,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          field_o
);
    logic [HW-1:0] h_act_end, hs_beg, h_half;
    logic [HW:0]   hs_fin;
    logic [VW-1:0] v_act_end, vs_beg;
    logic [VW:0]   vs_fin;
    logic          in_hs, vs_prog, vs_alt, in_vs, in_act;

    // Region edges derived from total, blank, delay and width.
    always_comb begin
        h_act_end = act.htot - act.hblk;
        hs_beg    = act.htot - act.hdly;
        hs_fin    = {1'b0, hs_beg} + {1'b0, act.hwid};
        h_half    = act.htot >> 1;
        v_act_end = act.vtot - {{(VW-VSW){1'b0}}, act.vblk};
        vs_beg    = act.vtot - {{(VW-VSW){1'b0}}, act.vdly};
        vs_fin    = {1'b0, vs_beg} + {{(VW-VSW+1){1'b0}}, act.vwid};
        in_hs     = (hcnt >= hs_beg) && ({1'b0, hcnt} < hs_fin);
        vs_prog   = (vcnt >= vs_beg) && ({1'b0, vcnt} < vs_fin);
        vs_alt    = (act.vwid != '0) &&
                    ((vcnt == vs_beg && hcnt >= h_half) ||
                     (vcnt > vs_beg && {1'b0, vcnt} < vs_fin) ||
                     ({1'b0, vcnt} == vs_fin && hcnt < h_half));
        in_vs     = (field && act.ilace) ? vs_alt : vs_prog;
        in_act    = (hcnt < h_act_end) && (vcnt < v_act_end);
    end

    // Output register stage with polarity applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
            field_o <= 1'b0;
        end else begin
            hsync_o <= (act.en && in_hs) ? act.hpol : ~act.hpol;
            vsync_o <= (act.en && in_vs) ? act.vpol : ~act.vpol;
            de_o    <= act.en && in_act;
            field_o <= field;
        end
    end

    // R9: no data enable after an idle cycle
    p_de_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !act.en |=> !de_o);
    // R7: idle hsync rests at the inverse of its polarity bit
    p_hs_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !act.en |=> (hsync_o == !$past(act.hpol)));
endmodule

// File: rtl/hv_raster_gen.sv
// Top of the raster timing generator: configuration banks, scan counters
// and sync decode, all on the pixel clock.
module hv_raster_gen
    import hv_timing_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          field_o
);
    tcfg_t         act;
    logic          nxt_ilace, load, field;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;

    hv_cfg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .load(load), .act(act), .nxt_ilace(nxt_ilace)
    );

    hv_scan_count u_count (
        .clk(clk), .rst_n(rst_n), .en(act.en), .htot(act.htot),
        .vtot(act.vtot), .nxt_ilace(nxt_ilace), .hcnt(hcnt), .vcnt(vcnt),
        .field(field), .load(load)
    );

    hv_sync_decode u_dec (
        .clk(clk), .rst_n(rst_n), .act(act), .hcnt(hcnt), .vcnt(vcnt),
        .field(field), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .field_o(field_o)
    );
endmodule

// File: tb/tb_hv_raster_gen.sv
module tb_hv_raster_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       hsync_o, vsync_o, de_o, field_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string phase = "R1 reset";

    // model: running (m_) and shadow (s_) banks, raster position
    int m_en, m_hp, m_vp, m_il, m_ht, m_hb, m_hd, m_hu, m_vt, m_vb, m_vd, m_vu;
    int s_en, s_hp, s_vp, s_il, s_ht, s_hb, s_hd, s_hu, s_vt, s_vb, s_vd, s_vu;
    int hc, vc, fld;
    int e_hs, e_vs, e_de, e_fld;

    hv_raster_gen dut (.*);

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s [%s] t=%0t: actual %0d expected %0d", tag, what, phase, $time, got, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic void model_eval;
        int hs0, hs1, vs0, vs1, half, ins, inv;
        hs0 = m_ht - m_hd; hs1 = hs0 + m_hu;
        vs0 = m_vt - m_vd; vs1 = vs0 + m_vu; half = m_ht / 2;
        ins = (hc >= hs0 && hc < hs1);
        if (fld != 0 && m_il != 0)
            inv = (m_vu != 0) && ((vc == vs0 && hc >= half) || (vc > vs0 && vc < vs1) ||
                                  (vc == vs1 && hc < half));
        else
            inv = (vc >= vs0 && vc < vs1);
        e_hs  = (m_en != 0 && ins) ? m_hp : 1 - m_hp;
        e_vs  = (m_en != 0 && inv) ? m_vp : 1 - m_vp;
        e_de  = (m_en != 0 && hc < m_ht - m_hb && vc < m_vt - m_vb) ? 1 : 0;
        e_fld = fld;
    endfunction

    function automatic void model_step;
        if (m_en == 0 || (hc == m_ht - 1 && vc == m_vt - 1)) begin
            fld = (m_en != 0 && s_il != 0) ? 1 - fld : 0;
            m_en = s_en; m_hp = s_hp; m_vp = s_vp; m_il = s_il;
            m_ht = s_ht; m_hb = s_hb; m_hd = s_hd; m_hu = s_hu;
            m_vt = s_vt; m_vb = s_vb; m_vd = s_vd; m_vu = s_vu;
            hc = 0; vc = 0;
        end else if (hc == m_ht - 1) begin
            hc = 0; vc++;
        end else begin
            hc++;
        end
    endfunction

    function automatic void model_write(input int a, input int d);
        case (a)
            0: begin s_en = d & 1; s_hp = (d >> 1) & 1; s_vp = (d >> 2) & 1; s_il = (d >> 3) & 1; end
            1: s_ht = (s_ht & 'hff00) | d;   2: s_ht = (s_ht & 'hff) | (d << 8);
            3: s_hb = (s_hb & 'hff00) | d;   4: s_hb = (s_hb & 'hff) | (d << 8);
            5: s_hd = (s_hd & 'hff00) | d;   6: s_hd = (s_hd & 'hff) | (d << 8);
            7: s_hu = (s_hu & 'hff00) | d;   8: s_hu = (s_hu & 'hff) | (d << 8);
            9: s_vt = (s_vt & 'hff00) | d;  10: s_vt = (s_vt & 'hff) | (d << 8);
            11: s_vb = d; 12: s_vd = d; 13: s_vu = d;
            default: ;   // R10: unmapped
        endcase
    endfunction

    // one clock: drive, model the edge, compare at the falling edge
    task automatic tick(input bit we, input int a, input int d);
        cfg_we = we; cfg_addr = a[4:0]; cfg_wdata = d[7:0];
        @(posedge clk);
        model_eval();
        model_step();
        if (we) model_write(a, d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (e_de == 0 && hc == 0 && vc == 0 && m_en == 0) begin
            check("R9", "de idle", de_o, e_de);
            check("R9", "hsync idle", hsync_o, e_hs);
            check("R9", "vsync idle", vsync_o, e_vs);
        end else begin
            check("R4", "de", de_o, e_de);
            check(m_hp != 0 ? "R5" : "R7", "hsync", hsync_o, e_hs);
            check(e_fld != 0 ? "R8" : "R6", "vsync", vsync_o, e_vs);
        end
        check("R8", "field", field_o, e_fld);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    // R2: full programming sequence, generator parked while fields change
    task automatic prog(input int ctrl, input int ht, input int hb, input int hd, input int hu,
                        input int vt, input int vb, input int vd, input int vu);
        tick(1, 0, ctrl & 'h6);
        tick(1, 1, ht & 'hff); tick(1, 2, ht >> 8);
        tick(1, 3, hb & 'hff); tick(1, 4, hb >> 8);
        tick(1, 5, hd & 'hff); tick(1, 6, hd >> 8);
        tick(1, 7, hu & 'hff); tick(1, 8, hu >> 8);
        tick(1, 9, vt & 'hff); tick(1, 10, vt >> 8);
        tick(1, 11, vb); tick(1, 12, vd); tick(1, 13, vu);
        tick(1, 0, ctrl);
    endtask

    task automatic run_frames(input int n);
        idle(n * m_ht * m_vt + 2);
    endtask

    initial begin
        m_en = 0; m_hp = 1; m_vp = 1; m_il = 0; m_ht = 0; m_hb = 0; m_hd = 0; m_hu = 0;
        m_vt = 0; m_vb = 0; m_vd = 0; m_vu = 0;
        s_en = 0; s_hp = 1; s_vp = 1; s_il = 0; s_ht = 0; s_hb = 0; s_hd = 0; s_hu = 0;
        s_vt = 0; s_vb = 0; s_vd = 0; s_vu = 0;
        hc = 0; vc = 0; fld = 0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "hsync reset", hsync_o, 0);
        check("R1", "vsync reset", vsync_o, 0);
        check("R1", "de reset", de_o, 0);
        check("R1", "field reset", field_o, 0);
        rst_n = 1'b1;

        phase = "R9 idle after reset";
        idle(6);

        phase = "R2 progressive active-high";
        prog('h7, 20, 6, 5, 3, 12, 3, 4, 2);
        run_frames(3);

        phase = "R3 mid-frame write";
        idle(37);
        tick(1, 1, 24);        // htotal grows, applied at next boundary
        tick(1, 3, 8);
        run_frames(2);

        phase = "R3 write on the boundary edge";
        while (!(hc == m_ht - 1 && vc == m_vt - 1)) tick(0, 0, 0);
        tick(1, 1, 18);        // misses this takeover, lands one frame later
        run_frames(3);

        phase = "R10 unmapped writes";
        for (int a = 14; a < 32; a++) tick(1, a, $urandom % 256);
        run_frames(1);

        phase = "R7 active-low syncs";
        prog('h1, 16, 4, 6, 2, 10, 2, 3, 2);
        run_frames(2);

        phase = "R8 interlace";
        prog('hF, 21, 5, 7, 3, 11, 2, 4, 3);
        run_frames(4);

        phase = "R8 interlace zero vertical width";
        prog('hB, 14, 3, 4, 2, 8, 2, 3, 0);
        run_frames(3);

        phase = "R6 random configurations";
        for (int k = 0; k < 20; k++) begin
            int ht, hb, hd, hu, vt, vb, vd, vu, c;
            ht = 8 + $urandom % 33;  hb = 1 + $urandom % (ht - 1);
            hd = 1 + $urandom % ht;  hu = $urandom % (hd + 1);
            vt = 6 + $urandom % 15;  vb = 1 + $urandom % (vt - 1);
            vd = 1 + $urandom % vt;  vu = $urandom % (vd + 1);
            c  = 1 | (($urandom % 8) << 1);
            prog(c, ht, hb, hd, hu, vt, vb, vd, vu);
            run_frames(3);
        end

        phase = "R9 disable mid-frame";
        idle(29);
        tick(1, 0, 'h6);
        idle(20);

        done = 1;
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog expired: actual running, expected complete");
            summary();
        end
    end
endmodule